// File: doc/BRIEF.md
# Nonvolatile Memory Command Controller

This block sits between a register bus and a small on-chip nonvolatile memory array. Software sets up a slow operation timebase by writing a divider register. It then loads an address, a data word and an opcode into a one-entry holding buffer. It commits that entry by writing 1 to the buffer-empty flag. An executor takes committed entries one at a time and keeps each one busy for a fixed number of timebase ticks. While the executor works, software can load and commit a second command, so two commands are in flight at once.

The timebase is the clock divided by the six-bit divide value plus one. An optional stage ahead of it divides by a further 8. Until the divider register has been written, no command is accepted. Status outputs report whether the buffer is empty, whether all work is complete, and whether an access error occurred. Two interrupt outputs follow the buffer-empty and all-done conditions when their enables are set. The memory array is modelled only through the executor's busy interval and its presented opcode, address and data.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset, buf_empty=1, cmd_done=1, div_set=0, acc_err=0, mem_busy=0, irq_empty=0, irq_done=0.
- R2: div_set becomes 1 on the first bus write with wr_sel=0 and stays 1 until reset.
- R3: The tick output is 0 until the divider is written. Afterwards it pulses once every (F+1)*M clock cycles. Here F=wr_data[5:0] and M=8 when wr_data[6]=1, else 1, both taken from the last write with wr_sel=0.
- R4: A command write (wr_sel=5) made while div_set=0 sets acc_err and loads nothing. A later launch therefore starts nothing.
- R5: Opcodes in wr_data[7:0] are 1 program, 2 erase, 3 erase verify, 4 sector erase abort and 5 sector modify. Any other value written with wr_sel=5 sets acc_err.
- R6: A launch (wr_sel=2, wr_data[0]=1) with a command loaded and acc_err=0 clears buf_empty. One cycle later the executor raises mem_busy and presents the opcode, address (wr_sel=3) and data (wr_sel=4). mem_busy stays high for 4 ticks (program), 20 (erase), 2 (erase verify) or 24 (sector modify).
- R7: A second command can be loaded and launched while mem_busy=1. buf_empty then stays 0 until the executor frees up, and the queued command starts one cycle after mem_busy falls.
- R8: An address, data or command write while buf_empty=0 sets acc_err and leaves the queued command unchanged.
- R9: A launch is ignored when no command is loaded or while acc_err=1. buf_empty stays 1 and mem_busy stays 0.
- R10: Writing wr_sel=2 with wr_data[1]=1 clears acc_err.
- R11: cmd_done is 1 exactly when buf_empty=1 and mem_busy=0.
- R12: irq_empty = buf_empty AND enable bit 0, and irq_done = cmd_done AND enable bit 1. Both enable bits are written with wr_sel=1.
- R13: An abort launched while an erase or sector modify runs ends mem_busy at the next tick and empties the buffer. It raises cmd_done in the same cycle. An abort launched while idle empties the buffer one cycle later without raising mem_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the source of the timebase |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 3 | Register select: 0 divider, 1 enables, 2 status, 3 address, 4 data, 5 command |
| wr_data | input | 16 | Bus write data |
| tick | output | 1 | Divided timebase pulse |
| buf_empty | output | 1 | Holding buffer can accept a command |
| cmd_done | output | 1 | Buffer empty and executor idle |
| div_set | output | 1 | Divider register has been written |
| acc_err | output | 1 | Access error flag |
| irq_empty | output | 1 | Buffer-empty interrupt |
| irq_done | output | 1 | All-done interrupt |
| mem_busy | output | 1 | Executor running an operation |
| mem_op | output | 3 | Opcode presented to the array |
| mem_addr | output | 16 | Address presented to the array |
| mem_data | output | 16 | Data presented to the array |

## Verification
The divider is swept over all 64 divide values with the prescale stage both off and on, and the measured tick spacing is compared with the computed product. This tells an off-by-one in either counter apart from a prescale that is ignored. Every opcode is run alone and the ticks are counted while mem_busy is high, so durations that are swapped or truncated show up. A run with a queued second command, and writes that collide with it, separates correct queueing from overwritten entries. Aborts are tried during erase, during sector modify and while idle, which checks that they cut the operation short in one tick and that the buffer is released.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_VERIFY = 3'd3,
        OP_ABORT  = 3'd4,
        OP_MODIFY = 3'd5
    } nvm_op_e;

    localparam logic [2:0] SEL_DIV  = 3'd0;
    localparam logic [2:0] SEL_CTRL = 3'd1;
    localparam logic [2:0] SEL_STAT = 3'd2;
    localparam logic [2:0] SEL_ADDR = 3'd3;
    localparam logic [2:0] SEL_DATA = 3'd4;
    localparam logic [2:0] SEL_CMD  = 3'd5;

    localparam int STAT_LAUNCH = 0;
    localparam int STAT_ERRCLR = 1;
    localparam int CTRL_IE_EMPTY = 0;
    localparam int CTRL_IE_DONE  = 1;

endpackage

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
    parameter int FLD_W   = 6,
    parameter int PRE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             pre_on,
    input  logic [FLD_W-1:0] fld,
    output logic             tick
);
    localparam int PRE_W = $clog2(PRE_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [FLD_W-1:0] cnt;
    } tg_state_t;

    tg_state_t q, d;
    logic strobe;
    logic wrap;

    always_comb begin
        strobe = !pre_on || (q.pre_cnt == PRE_LAST);
        wrap   = (q.cnt >= fld);
        tick   = en && strobe && wrap;
        d = q;
        if (clr) begin
            d.pre_cnt = '0;
            d.cnt     = '0;
        end else if (en) begin
            if (pre_on)
                d.pre_cnt = (q.pre_cnt == PRE_LAST) ? '0 : q.pre_cnt + 1'b1;
            if (strobe)
                d.cnt = wrap ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/nvm_op_engine.sv
module nvm_op_engine
    import nvm_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int T_PROG   = 4,
    parameter int T_ERASE  = 20,
    parameter int T_VERIFY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  nvm_op_e           start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              abort_req,
    output logic              busy,
    output nvm_op_e           op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              abortable
);
    localparam int T_MAX = T_ERASE + T_PROG;
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        logic              busy;
        nvm_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  rem;
    } eng_state_t;

    eng_state_t q, d;

    function automatic logic [CNT_W-1:0] op_ticks(input nvm_op_e o);
        case (o)
            OP_PROG:   op_ticks = CNT_W'(T_PROG);
            OP_ERASE:  op_ticks = CNT_W'(T_ERASE);
            OP_VERIFY: op_ticks = CNT_W'(T_VERIFY);
            OP_MODIFY: op_ticks = CNT_W'(T_MAX);
            default:   op_ticks = '0;
        endcase
    endfunction

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.op   = start_op;
                d.addr = start_addr;
                d.data = start_data;
                d.rem  = op_ticks(start_op);
            end
        end else if (tick) begin
            if (abort_req || q.rem <= 1) begin
                d.busy = 1'b0;
                d.rem  = '0;
            end else begin
                d.rem = q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.op   <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.busy;
    assign op        = q.op;
    assign addr      = q.addr;
    assign data      = q.data;
    assign abortable = q.busy && (q.op == OP_ERASE || q.op == OP_MODIFY);

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_pkg::*;
#(
    parameter int BUS_W    = 16,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int FLD_W    = 6,
    parameter int PRE_DIV  = 8,
    parameter int T_PROG   = 4,
    parameter int T_ERASE  = 20,
    parameter int T_VERIFY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              tick,
    output logic              buf_empty,
    output logic              cmd_done,
    output logic              div_set,
    output logic              acc_err,
    output logic              irq_empty,
    output logic              irq_done,
    output logic              mem_busy,
    output logic [2:0]        mem_op,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    typedef struct packed {
        logic              div_set;
        logic              pre;
        logic [FLD_W-1:0]  fld;
        logic              ie_empty;
        logic              ie_done;
        logic              buf_empty;
        logic              loaded;
        logic              acc_err;
        nvm_op_e           buf_op;
        logic [ADDR_W-1:0] buf_addr;
        logic [DATA_W-1:0] buf_data;
    } ctl_state_t;

    ctl_state_t q, d;

    logic       div_clr;
    logic       eng_start;
    logic       eng_busy;
    logic       eng_abortable;
    logic       abort_req;
    logic [7:0] opc;
    logic       opc_ok;
    nvm_op_e    eng_op;

    nvm_tick_gen #(
        .FLD_W   (FLD_W),
        .PRE_DIV (PRE_DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (q.div_set),
        .clr    (div_clr),
        .pre_on (q.pre),
        .fld    (q.fld),
        .tick   (tick)
    );

    nvm_op_engine #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .T_PROG   (T_PROG),
        .T_ERASE  (T_ERASE),
        .T_VERIFY (T_VERIFY)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (eng_start),
        .start_op   (q.buf_op),
        .start_addr (q.buf_addr),
        .start_data (q.buf_data),
        .abort_req  (abort_req),
        .busy       (eng_busy),
        .op         (eng_op),
        .addr       (mem_addr),
        .data       (mem_data),
        .abortable  (eng_abortable)
    );

    assign abort_req = !q.buf_empty && (q.buf_op == OP_ABORT) && eng_abortable;

    always_comb begin
        d         = q;
        div_clr   = 1'b0;
        eng_start = 1'b0;
        opc       = wr_data[7:0];
        opc_ok    = (opc >= 8'd1) && (opc <= 8'd5);

        // bus side: loading, launching and configuration
        if (wr_en) begin
            case (wr_sel)
                SEL_DIV: begin
                    d.fld     = wr_data[FLD_W-1:0];
                    d.pre     = wr_data[FLD_W];
                    d.div_set = 1'b1;
                    div_clr   = 1'b1;
                end
                SEL_CTRL: begin
                    d.ie_empty = wr_data[CTRL_IE_EMPTY];
                    d.ie_done  = wr_data[CTRL_IE_DONE];
                end
                SEL_STAT: begin
                    if (wr_data[STAT_ERRCLR])
                        d.acc_err = 1'b0;
                    if (wr_data[STAT_LAUNCH] && q.buf_empty && q.loaded && !q.acc_err)
                        d.buf_empty = 1'b0;
                end
                SEL_ADDR: begin
                    if (!q.buf_empty) d.acc_err  = 1'b1;
                    else              d.buf_addr = wr_data[ADDR_W-1:0];
                end
                SEL_DATA: begin
                    if (!q.buf_empty) d.acc_err  = 1'b1;
                    else              d.buf_data = wr_data[DATA_W-1:0];
                end
                SEL_CMD: begin
                    if (!q.div_set || !q.buf_empty || !opc_ok) begin
                        d.acc_err = 1'b1;
                    end else begin
                        d.buf_op = nvm_op_e'(opc[2:0]);
                        d.loaded = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // executor side: hand the committed entry over or consume an abort
        if (!q.buf_empty) begin
            if (q.buf_op == OP_ABORT) begin
                if (!eng_busy || (eng_abortable && tick)) begin
                    d.buf_empty = 1'b1;
                    d.loaded    = 1'b0;
                end
            end else if (!eng_busy) begin
                eng_start   = 1'b1;
                d.buf_empty = 1'b1;
                d.loaded    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.buf_empty <= 1'b1;
            q.buf_op    <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign buf_empty = q.buf_empty;
    assign cmd_done  = q.buf_empty && !eng_busy;
    assign div_set   = q.div_set;
    assign acc_err   = q.acc_err;
    assign irq_empty = q.ie_empty && q.buf_empty;
    assign irq_done  = q.ie_done && cmd_done;
    assign mem_busy  = eng_busy;
    assign mem_op    = eng_op;

endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       div_set,
    input logic       buf_empty,
    input logic       cmd_done,
    input logic       irq_empty,
    input logic       mem_busy,
    input logic [2:0] mem_op
);
    AST_DIV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        div_set |=> div_set);                                             // R2
    AST_NO_TICK_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
        !div_set |-> !tick);                                              // R3
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_busy && $past(mem_busy)) |-> (mem_op == $past(mem_op)));    // R6
    AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_busy) |-> $past(tick));                                 // R13
    AST_START_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_busy) |-> buf_empty);                                   // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!mem_busy && buf_empty));                           // R11
    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> buf_empty);                                         // R12
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .div_set   (div_set),
    .buf_empty (buf_empty),
    .cmd_done  (cmd_done),
    .irq_empty (irq_empty),
    .mem_busy  (mem_busy),
    .mem_op    (mem_op)
);

// File: tb/nvm_cmd_ctrl_bench.sv
module nvm_cmd_ctrl_bench;
    import nvm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        tick, buf_empty, cmd_done, div_set, acc_err;
    logic        irq_empty, irq_done, mem_busy;
    logic [2:0]  mem_op;
    logic [15:0] mem_addr, mem_data;

    int n_chk  = 0;
    int n_fail = 0;
    int n;
    int seen;

    always #5 clk = ~clk;

    nvm_cmd_ctrl u_nvm_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick(tick), .buf_empty(buf_empty), .cmd_done(cmd_done), .div_set(div_set),
        .acc_err(acc_err), .irq_empty(irq_empty), .irq_done(irq_done),
        .mem_busy(mem_busy), .mem_op(mem_op), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic bus_wr(input logic [2:0] s, input logic [15:0] v);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic tick_period(output int p);
        @(negedge clk);
        while (!tick) @(negedge clk);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!tick);
    endtask

    task automatic count_ticks(output int c);
        c = 0;
        @(negedge clk);
        while (mem_busy) begin
            if (tick) c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ops  [4] = '{1, 2, 3, 5};
        int durs [4] = '{4, 20, 2, 24};
        int p;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 cmd_done", cmd_done, 1);
        chk("R1 div_set", div_set, 0);
        chk("R1 acc_err", acc_err, 0);
        chk("R1 mem_busy", mem_busy, 0);
        chk("R1 irqs", {irq_empty, irq_done}, 0);

        // R3 silent timebase before configuration
        seen = 0;
        repeat (16) begin @(negedge clk); if (tick) seen++; end
        chk("R3 no tick before divider write", seen, 0);

        // R4 command before divider
        bus_wr(SEL_CMD, 16'(OP_PROG));
        chk("R4 acc_err on early command", acc_err, 1);
        bus_wr(SEL_STAT, 16'h2);
        chk("R10 acc_err cleared", acc_err, 0);
        bus_wr(SEL_STAT, 16'h1);
        step;
        chk("R4 rejected command not launched", {buf_empty, mem_busy}, 2'b10);
        chk("R2 div_set still clear", div_set, 0);

        // R3 divider sweep
        for (int pre = 0; pre < 2; pre++) begin
            for (int f = 0; f < 64; f++) begin
                bus_wr(SEL_DIV, 16'(pre * 64 + f));
                tick_period(p);
                chk($sformatf("R3 period pre=%0d f=%0d", pre, f), p, (f + 1) * (pre ? 8 : 1));
            end
            chk("R2 div_set sticky", div_set, 1);
        end
        bus_wr(SEL_DIV, 16'h0002);

        // R5 illegal opcodes
        bus_wr(SEL_CMD, 16'h0000);
        chk("R5 opcode 0 rejected", acc_err, 1);
        bus_wr(SEL_STAT, 16'h2);
        bus_wr(SEL_CMD, 16'h0007);
        chk("R5 opcode 7 rejected", acc_err, 1);
        bus_wr(SEL_STAT, 16'h2);
        bus_wr(SEL_CMD, 16'h0021);
        chk("R5 opcode 0x21 rejected", acc_err, 1);
        bus_wr(SEL_STAT, 16'h2);

        // R6 single operations
        for (int k = 0; k < 4; k++) begin
            bus_wr(SEL_ADDR, 16'h0100 + 16'(k));
            bus_wr(SEL_DATA, 16'h00A0 + 16'(k));
            bus_wr(SEL_CMD, 16'(ops[k]));
            bus_wr(SEL_STAT, 16'h1);
            chk("R6 launch clears buf_empty", buf_empty, 0);
            chk("R11 not done while queued", cmd_done, 0);
            step;
            chk("R6 busy after handover", mem_busy, 1);
            chk("R6 presented opcode", mem_op, ops[k]);
            chk("R6 presented address", mem_addr, 32'h100 + k);
            chk("R6 presented data", mem_data, 32'hA0 + k);
            chk("R6 buffer freed", buf_empty, 1);
            chk("R11 not done while busy", cmd_done, 0);
            count_ticks(n);
            chk($sformatf("R6 tick count op %0d", ops[k]), n, durs[k]);
            chk("R11 done when idle", cmd_done, 1);
        end

        // R7 and R8 queueing
        bus_wr(SEL_ADDR, 16'h0200);
        bus_wr(SEL_CMD, 16'(OP_ERASE));
        bus_wr(SEL_STAT, 16'h1);
        step;
        chk("R7 erase running", mem_busy, 1);
        bus_wr(SEL_ADDR, 16'h0055);
        bus_wr(SEL_DATA, 16'h1234);
        bus_wr(SEL_CMD, 16'(OP_PROG));
        bus_wr(SEL_STAT, 16'h1);
        chk("R7 second command queued", buf_empty, 0);
        chk("R7 first still running", mem_op, OP_ERASE);
        bus_wr(SEL_ADDR, 16'h0077);
        chk("R8 address write while full", acc_err, 1);
        bus_wr(SEL_STAT, 16'h2);
        bus_wr(SEL_CMD, 16'(OP_VERIFY));
        chk("R8 command write while full", acc_err, 1);
        bus_wr(SEL_STAT, 16'h2);
        @(negedge clk);
        while (mem_busy) @(negedge clk);
        chk("R7 still queued in gap cycle", buf_empty, 0);
        chk("R11 not done in gap cycle", cmd_done, 0);
        step;
        chk("R7 queued command started", mem_busy, 1);
        chk("R8 queued opcode intact", mem_op, OP_PROG);
        chk("R8 queued address intact", mem_addr, 32'h55);
        chk("R8 queued data intact", mem_data, 32'h1234);
        count_ticks(n);
        chk("R7 queued program duration", n, 4);

        // R12 interrupts
        bus_wr(SEL_CTRL, 16'h3);
        chk("R12 both irqs when idle", {irq_empty, irq_done}, 2'b11);
        bus_wr(SEL_CMD, 16'(OP_VERIFY));
        bus_wr(SEL_STAT, 16'h1);
        chk("R12 irqs low while queued", {irq_empty, irq_done}, 2'b00);
        step;
        chk("R12 only empty irq while busy", {irq_empty, irq_done}, 2'b10);
        count_ticks(n);
        chk("R12 done irq after finish", irq_done, 1);
        bus_wr(SEL_CTRL, 16'h1);
        chk("R12 done irq masked", {irq_empty, irq_done}, 2'b10);
        bus_wr(SEL_CTRL, 16'h0);
        chk("R12 both masked", {irq_empty, irq_done}, 2'b00);

        // R13 abort during erase and sector modify
        for (int k = 0; k < 2; k++) begin
            bus_wr(SEL_CMD, 16'(k == 0 ? OP_ERASE : OP_MODIFY));
            bus_wr(SEL_STAT, 16'h1);
            step;
            repeat (6) step;
            chk("R13 long op running", mem_busy, 1);
            bus_wr(SEL_CMD, 16'(OP_ABORT));
            bus_wr(SEL_STAT, 16'h1);
            count_ticks(n);
            chk("R13 abort ends at next tick", n, 1);
            chk("R13 buffer emptied", buf_empty, 1);
            chk("R13 done after abort", cmd_done, 1);
        end
        bus_wr(SEL_CMD, 16'(OP_ABORT));
        bus_wr(SEL_STAT, 16'h1);
        chk("R13 idle abort queued", buf_empty, 0);
        step;
        chk("R13 idle abort consumed", {buf_empty, mem_busy, cmd_done}, 3'b101);

        // R9 ignored launches
        bus_wr(SEL_STAT, 16'h1);
        step;
        chk("R9 launch with nothing loaded", {buf_empty, mem_busy}, 2'b10);
        bus_wr(SEL_CMD, 16'(OP_PROG));
        bus_wr(SEL_CMD, 16'h0009);
        chk("R5 opcode 9 rejected", acc_err, 1);
        bus_wr(SEL_STAT, 16'h1);
        step;
        chk("R9 launch blocked by acc_err", {buf_empty, mem_busy}, 2'b10);
        bus_wr(SEL_STAT, 16'h2);
        chk("R10 clear before relaunch", acc_err, 0);
        bus_wr(SEL_STAT, 16'h1);
        step;
        chk("R9 relaunch runs", mem_busy, 1);
        chk("R9 relaunch opcode", mem_op, OP_PROG);
        count_ticks(n);
        chk("R6 program after relaunch", n, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule